// File: doc/BRIEF.md
# Memory Window Remap Decoder

This block sits in front of a controller's memory-mapped register space and carves one remapped window out of it. A single 32-bit configuration word gives where the window starts and how long it is, both counted in 128-byte units, plus an enable bit. Every incoming access carries a byte offset measured from the controller base. An access that lands inside the window is sent to a secondary device port, and its offset is rebased so that the first byte of the window becomes offset zero. Any other access goes to the native port with its offset unchanged.

The configuration fields can be written only once after a full reset. A function-level reset does not touch them or the write lock. It only cancels a result that is still in flight. If a programmed window would run past a parameterised aperture, the block raises a configuration-error flag and stops remapping until the configuration is fixed by a full reset.

Top module: `remap_window_decoder`

## Requirements
- R1: After a full reset the configuration word reads 0x001002DE. This is start 0x010 in bits 27:16, size 0x16F in bits 12:1 and enable 0 in bit 0.
- R2: Bits 31:28 and 15:13 of the configuration word always read zero, and writing ones to them has no effect.
- R3: The first configuration write after a full reset sets the start, size and enable fields. Every later write is ignored until the next full reset.
- R4: A function-level reset leaves the configuration word and the write lock unchanged. A write made after it is still ignored.
- R5: An access at byte offset A is a hit when start×128 ≤ A < (start+size+1)×128. The lower bound is inclusive and the upper bound is exclusive.
- R6: On a hit the secondary port gets the offset A − start×128.
- R7: On a miss the native port gets offset A unchanged.
- R8: While the enable bit (bit 0) is 0, no access goes to the secondary port.
- R9: The configuration-error output is 1 exactly when (start+size+1)×128 is greater than the aperture size (default 524288 bytes). While it is 1, no access goes to the secondary port.
- R10: Each accepted request produces exactly one valid result, on either the native port or the secondary port, one clock after it is accepted.
- R11: A request sampled while the function-level reset is asserted produces no valid result on either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Full reset, active low. Restores the defaults and clears the write lock. |
| flr | input | 1 | Function-level reset, active high. Clears only the in-flight result. |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current configuration word |
| cfg_err | output | 1 | The window extends past the aperture |
| req_valid | input | 1 | Access request valid |
| req_offset | input | OFS_W | Byte offset of the access from the controller base |
| nat_valid | output | 1 | Result valid on the native port |
| nat_offset | output | OFS_W | Offset for the native port |
| sec_valid | output | 1 | Result valid on the secondary port |
| sec_offset | output | OFS_W | Rebased offset for the secondary port |

## Verification
The configuration word and the error flag are combinational views of registered state. The bench drives a write on a falling edge and reads both of them back on the next falling edge, after the rising edge that stored the write. Routing results come out one clock after the request. The bench raises a request on a falling edge, lowers it on the next falling edge, and samples both ports at that moment, which is one rising edge after acceptance. This timing is also how it confirms that a request sampled under function-level reset yields nothing. The checker asserts the same one-cycle relation from the request pins to the output pins.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int UNIT_LG   = 7;
  localparam int FIELD_W   = 12;
  localparam int START_LSB = 16;
  localparam int SIZE_LSB  = 1;
  localparam int EN_BIT    = 0;

  localparam logic [FIELD_W-1:0] START_RST = 12'h010;
  localparam logic [FIELD_W-1:0] SIZE_RST  = 12'h16F;

  typedef struct packed {
    logic [FIELD_W-1:0] start;
    logic [FIELD_W-1:0] size;
    logic               en;
  } remap_cfg_t;
endpackage

// File: rtl/remap_cfg_reg.sv
module remap_cfg_reg
  import remap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output remap_cfg_t  cfg,
  output logic        cfg_locked,
  output logic [31:0] cfg_rdata
);
  // Only the full reset clears these registers. The function-level reset is not an input here.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.start  <= START_RST;
      cfg.size   <= SIZE_RST;
      cfg.en     <= 1'b0;
      cfg_locked <= 1'b0;
    end else if (cfg_we && !cfg_locked) begin
      cfg.start  <= cfg_wdata[START_LSB +: FIELD_W];
      cfg.size   <= cfg_wdata[SIZE_LSB +: FIELD_W];
      cfg.en     <= cfg_wdata[EN_BIT];
      cfg_locked <= 1'b1;
    end
  end

  assign cfg_rdata = {4'b0000, cfg.start, 3'b000, cfg.size, cfg.en};
endmodule

// File: rtl/remap_window_calc.sv
module remap_window_calc
  import remap_pkg::*;
#(
  parameter int          OFS_W          = 32,
  parameter int unsigned APERTURE_BYTES = 524288
) (
  input  remap_cfg_t   cfg,
  output logic [OFS_W:0] win_lo,
  output logic [OFS_W:0] win_hi,
  output logic           cfg_err,
  output logic           remap_on
);
  localparam int CW = OFS_W + 1;

  function automatic logic [CW-1:0] units_to_bytes(input logic [FIELD_W+1:0] units);
    return CW'(units) << UNIT_LG;
  endfunction

  function automatic logic [FIELD_W+1:0] end_units(input logic [FIELD_W-1:0] start,
                                                   input logic [FIELD_W-1:0] size);
    return (FIELD_W+2)'(start) + (FIELD_W+2)'(size) + (FIELD_W+2)'(1);
  endfunction

  assign win_lo   = units_to_bytes((FIELD_W+2)'(cfg.start));
  assign win_hi   = units_to_bytes(end_units(cfg.start, cfg.size));
  assign cfg_err  = win_hi > CW'(APERTURE_BYTES);
  assign remap_on = cfg.en && !cfg_err;
endmodule

// File: rtl/remap_router.sv
module remap_router #(
  parameter int OFS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flr,
  input  logic             req_valid,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [OFS_W:0]   win_lo,
  input  logic [OFS_W:0]   win_hi,
  input  logic             remap_on,
  output logic             win_hit,
  output logic             nat_valid,
  output logic [OFS_W-1:0] nat_offset,
  output logic             sec_valid,
  output logic [OFS_W-1:0] sec_offset
);
  logic [OFS_W:0]   addr_ext;
  logic [OFS_W-1:0] rebased;

  assign addr_ext = {1'b0, req_offset};
  assign win_hit  = remap_on && (addr_ext >= win_lo) && (addr_ext < win_hi);
  assign rebased  = req_offset - win_lo[OFS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nat_valid  <= 1'b0;
      sec_valid  <= 1'b0;
      nat_offset <= '0;
      sec_offset <= '0;
    end else if (flr) begin
      nat_valid <= 1'b0;
      sec_valid <= 1'b0;
    end else begin
      nat_valid <= req_valid && !win_hit;
      sec_valid <= req_valid && win_hit;
      if (req_valid && !win_hit) nat_offset <= req_offset;
      if (req_valid && win_hit)  sec_offset <= rebased;
    end
  end
endmodule

// File: rtl/remap_window_decoder.sv
module remap_window_decoder
  import remap_pkg::*;
#(
  parameter int          OFS_W          = 32,
  parameter int unsigned APERTURE_BYTES = 524288
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flr,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic             cfg_err,
  input  logic             req_valid,
  input  logic [OFS_W-1:0] req_offset,
  output logic             nat_valid,
  output logic [OFS_W-1:0] nat_offset,
  output logic             sec_valid,
  output logic [OFS_W-1:0] sec_offset
);
  remap_cfg_t     cfg;
  logic           cfg_locked;
  logic [OFS_W:0] win_lo;
  logic [OFS_W:0] win_hi;
  logic           remap_on;
  logic           win_hit;

  remap_cfg_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg        (cfg),
    .cfg_locked (cfg_locked),
    .cfg_rdata  (cfg_rdata)
  );

  remap_window_calc #(.OFS_W(OFS_W), .APERTURE_BYTES(APERTURE_BYTES)) u_calc (
    .cfg      (cfg),
    .win_lo   (win_lo),
    .win_hi   (win_hi),
    .cfg_err  (cfg_err),
    .remap_on (remap_on)
  );

  remap_router #(.OFS_W(OFS_W)) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .flr        (flr),
    .req_valid  (req_valid),
    .req_offset (req_offset),
    .win_lo     (win_lo),
    .win_hi     (win_hi),
    .remap_on   (remap_on),
    .win_hit    (win_hit),
    .nat_valid  (nat_valid),
    .nat_offset (nat_offset),
    .sec_valid  (sec_valid),
    .sec_offset (sec_offset)
  );
endmodule

// File: rtl/remap_window_decoder_chk.sv
module remap_window_decoder_chk #(
  parameter int OFS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flr,
  input logic             cfg_we,
  input logic [31:0]      cfg_rdata,
  input logic             cfg_err,
  input logic             cfg_locked,
  input logic             req_valid,
  input logic [OFS_W-1:0] req_offset,
  input logic             nat_valid,
  input logic [OFS_W-1:0] nat_offset,
  input logic             sec_valid
);
  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> $stable(cfg_rdata));

  // R4
  flr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flr && !cfg_we) |=> $stable(cfg_rdata));

  // R7
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !flr) |=> (nat_valid |-> nat_offset == $past(req_offset)));

  // R8
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cfg_rdata[0]) |=> !sec_valid);

  // R9
  err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cfg_err) |=> !sec_valid);

  // R10
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !flr) |=> $countones({nat_valid, sec_valid}) == 1);

  // R10
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(nat_valid || sec_valid));

  // R11
  flr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flr |=> !(nat_valid || sec_valid));
endmodule

bind remap_window_decoder remap_window_decoder_chk #(.OFS_W(OFS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flr        (flr),
  .cfg_we     (cfg_we),
  .cfg_rdata  (cfg_rdata),
  .cfg_err    (cfg_err),
  .cfg_locked (cfg_locked),
  .req_valid  (req_valid),
  .req_offset (req_offset),
  .nat_valid  (nat_valid),
  .nat_offset (nat_offset),
  .sec_valid  (sec_valid)
);

// File: tb/remap_window_decoder_bench.sv
module remap_window_decoder_bench;
  localparam int OFS_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             flr = 1'b0;
  logic             cfg_we = 1'b0;
  logic [31:0]      cfg_wdata = '0;
  logic [31:0]      cfg_rdata;
  logic             cfg_err;
  logic             req_valid = 1'b0;
  logic [OFS_W-1:0] req_offset = '0;
  logic             nat_valid, sec_valid;
  logic [OFS_W-1:0] nat_offset, sec_offset;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  remap_window_decoder u_remap_window_decoder (
    .clk(clk), .rst_n(rst_n), .flr(flr),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .req_valid(req_valid), .req_offset(req_offset),
    .nat_valid(nat_valid), .nat_offset(nat_offset),
    .sec_valid(sec_valid), .sec_offset(sec_offset)
  );

  // Window for the table: start 4 units (512 B) and size 3, which covers 4 units. Hits are 512..1023.
  localparam int NV = 8;
  localparam logic [31:0] V_OFS [NV] = '{32'd0, 32'd511, 32'd512, 32'd700,
                                         32'd1023, 32'd1024, 32'h0001_0000, 32'hFFFF_FFFF};
  localparam logic        V_SEC [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [31:0] V_EXP [NV] = '{32'd0, 32'd511, 32'd0, 32'd188,
                                         32'd511, 32'd1024, 32'h0001_0000, 32'hFFFF_FFFF};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic full_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic write_cfg(input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // The result is sampled on the falling edge one rising edge after the request.
  task automatic send(input logic [31:0] a, input logic use_flr,
                      output logic nv, output logic sv, output logic [31:0] no, output logic [31:0] so);
    @(negedge clk); req_valid = 1'b1; req_offset = a; flr = use_flr;
    @(negedge clk); req_valid = 1'b0; flr = 1'b0;
    nv = nat_valid; sv = sec_valid; no = nat_offset; so = sec_offset;
  endtask

  task automatic route_check(input string req, input logic [31:0] a,
                             input logic exp_sec, input logic [31:0] exp_ofs);
    logic nv, sv;
    logic [31:0] no, so;
    send(a, 1'b0, nv, sv, no, so);
    check(req, {30'd0, nv, sv}, exp_sec ? 32'd1 : 32'd2);
    check(req, exp_sec ? so : no, exp_ofs);
  endtask

  initial begin
    logic nv, sv;
    logic [31:0] no, so;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 defaults
    check("R1", cfg_rdata, 32'h0010_02DE);
    check("R9", {31'd0, cfg_err}, 32'd0);
    // R8: enable clear, the access is inside the default window range (2048..)
    route_check("R8", 32'd2048, 1'b0, 32'd2048);
    route_check("R8", 32'd3000, 1'b0, 32'd3000);
    // R2, R3: the first write sets reserved bits and fields
    write_cfg(32'hF004_E007);
    check("R2", cfg_rdata, 32'h0004_0007);
    write_cfg(32'h00FF_00FF);
    check("R3", cfg_rdata, 32'h0004_0007);
    // R4: the function-level reset keeps the contents and the lock
    @(negedge clk); flr = 1'b1;
    @(negedge clk); flr = 1'b0;
    check("R4", cfg_rdata, 32'h0004_0007);
    write_cfg(32'h0001_0001);
    check("R4", cfg_rdata, 32'h0004_0007);
    // R5 R6 R7 R10: table walk
    for (int i = 0; i < NV; i++) begin
      route_check(V_SEC[i] ? "R5/R6" : "R5/R7", V_OFS[i], V_SEC[i], V_EXP[i]);
    end
    // R11: a request under the function-level reset yields nothing
    send(32'd600, 1'b1, nv, sv, no, so);
    check("R11", {30'd0, nv, sv}, 32'd0);
    route_check("R10", 32'd600, 1'b1, 32'd88);
    // R3: a full reset restores the defaults and unlocks
    full_reset();
    check("R1", cfg_rdata, 32'h0010_02DE);
    // R9: the window runs past the aperture: start 0xFFF, size 0x010, enable
    write_cfg(32'h0FFF_0021);
    check("R9", {31'd0, cfg_err}, 32'd1);
    route_check("R9", 32'd524160, 1'b0, 32'd524160);
    // R9 boundary: the end equals the aperture, so there is no error
    full_reset();
    write_cfg(32'h0F00_01FF);
    check("R9", {31'd0, cfg_err}, 32'd0);
    route_check("R5", 32'd524287, 1'b1, 32'd32767);
    route_check("R5", 32'd491520, 1'b1, 32'd0);
    route_check("R7", 32'd491519, 1'b0, 32'd491519);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule